// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles one conditional branch per start strobe. It receives the 32-bit branch instruction word, the address of that instruction, the count register, the link register, the 32-bit condition register and a flag that selects 64-bit or 32-bit addressing. One cycle after the strobe it presents the taken decision, the next instruction address, the new count register value and the new link register value. These results stay on the outputs until the next strobe.

A 5-bit option field in the instruction word chooses, in any combination, two tests. One decrements the count register and tests the result for zero or non-zero. The other compares one selected condition register bit with a required polarity. The branch target comes from a sign-extended displacement, used either relative to the current address or as an absolute address, or from the link or count register in the register-indirect form. The `indirect_i` input selects the register-indirect form. In 32-bit mode every address the block computes is cut to its low 32 bits.

Top module: `branch_resolver`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe, `done_o` and `taken_o` are 0 and `next_addr_o`, `count_o` and `link_o` are all zero.
- R2: `done_o` is 1 exactly in the cycle after a cycle with `start_i` high. Without a strobe, `done_o` is 0 and the four result outputs hold their values.
- R3: When option bit 2 (instruction bit 23) is 0, `count_o` is `count_i` minus 1, wrapping modulo 2^ADDR_W. When option bit 2 is 1, `count_o` equals `count_i`.
- R4: When option bit 2 is 0, the count test passes only if (decremented count == 0) equals option bit 1 (instruction bit 22). When option bit 2 is 1, the count test passes.
- R5: The condition index is instruction bits 20..16. The selected bit is `cond_i[31 - index]`. When option bit 4 (instruction bit 25) is 0, the condition test passes only if that bit equals option bit 3 (instruction bit 24). When option bit 4 is 1, the condition test passes.
- R6: `taken_o` is 1 exactly when both the count test and the condition test pass.
- R7: In the displacement form (`indirect_i` = 0), the target is instruction bits 15..2 followed by two zero bits, sign-extended from bit 15. The target is that value added to `cur_addr_i` when instruction bit 1 is 0, and that value alone when instruction bit 1 is 1.
- R8: In the register-indirect form (`indirect_i` = 1), the target is the count register value as it was before any decrement when instruction bit 10 is 1. Otherwise the target is the incoming `link_i`.
- R9: When the branch is taken, `next_addr_o` is the target. When it is not taken, `next_addr_o` is `cur_addr_i` + 4.
- R10: When instruction bit 0 is 1, `link_o` is `cur_addr_i` + 4 whether the branch is taken or not. When instruction bit 0 is 0, `link_o` equals `link_i`.
- R11: When `wide_i` is 0, `next_addr_o` and any link value written under R10 have their upper ADDR_W-32 bits cleared. This truncation applies after the addition, so carries out of bit 31 are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe: evaluate the presented branch |
| insn_i | input | 32 | Branch instruction word |
| indirect_i | input | 1 | 1 = register-indirect form, 0 = displacement form |
| cur_addr_i | input | ADDR_W | Address of the branch instruction |
| count_i | input | ADDR_W | Count register before the branch |
| link_i | input | ADDR_W | Link register before the branch |
| cond_i | input | 32 | Condition register |
| wide_i | input | 1 | 1 = 64-bit addressing, 0 = 32-bit addressing |
| done_o | output | 1 | Results valid (one cycle after the strobe) |
| taken_o | output | 1 | Branch taken |
| next_addr_o | output | ADDR_W | Next instruction address |
| count_o | output | ADDR_W | Updated count register |
| link_o | output | ADDR_W | Updated link register |

## Verification
Every result is registered once, so a wrong decision or a wrong address shows at the ports in the first cycle after the strobe. Nothing wrong can stay hidden for longer than one operation. An error in the count decrement shows in two ways: `count_o` is wrong, and a zero or non-zero test flips `taken_o` and `next_addr_o` at the same time. A wrong bit index shows as a wrong decision only for some index values, so the sweep moves the index along with all 32 option codes. A missing truncation shows only in 32-bit mode, with addresses whose upper half is non-zero or whose low half carries out.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int INSN_W = 32;
  localparam int CR_W   = 32;
  localparam int OPT_LO = 21;
  localparam int IDX_LO = 16;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    TGT_REL   = 2'd0,
    TGT_ABS   = 2'd1,
    TGT_LINK  = 2'd2,
    TGT_COUNT = 2'd3
  } tgt_src_e;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [ADDR_W-1:0] count_in,
  input  logic [CR_W-1:0]   cond_in,
  output logic [ADDR_W-1:0] count_out,
  output logic              go
);
  logic [4:0]        opt;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  pos;
  logic              dec_en;
  logic [ADDR_W-1:0] count_dec;
  logic              cnt_zero;
  logic              cnt_ok;
  logic              cr_bit;
  logic              cr_ok;

  always_comb begin
    opt       = insn[OPT_LO +: 5];
    idx       = insn[IDX_LO +: IDX_W];
    pos       = IDX_W'(CR_W - 1) - idx;
    dec_en    = ~opt[2];
    count_dec = count_in - ADDR_W'(1);
    cnt_zero  = ~|count_dec;
    count_out = dec_en ? count_dec : count_in;
    cnt_ok    = ~dec_en | (cnt_zero == opt[1]);
    cr_bit    = cond_in[pos];
    cr_ok     = opt[4] | (cr_bit == opt[3]);
    go        = cnt_ok & cr_ok;
  end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import br_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              indirect,
  input  logic              wide,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] count_in,
  input  logic [ADDR_W-1:0] link_in,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] seq_addr
);
  localparam int HI_W = ADDR_W - 32;

  tgt_src_e          src;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] raw_tgt;
  logic [ADDR_W-1:0] raw_seq;
  logic [ADDR_W-1:0] keep_mask;

  generate
    if (HI_W > 0) begin : g_mask
      assign keep_mask = wide ? '1 : {{HI_W{1'b0}}, 32'hFFFF_FFFF};
    end else begin : g_nomask
      assign keep_mask = '1;
    end
  endgenerate

  always_comb begin
    disp = {{(ADDR_W-16){insn[15]}}, insn[15:2], 2'b00};
    if (indirect) src = insn[10] ? TGT_COUNT : TGT_LINK;
    else          src = insn[1]  ? TGT_ABS   : TGT_REL;
    unique case (src)
      TGT_REL:   raw_tgt = cur_addr + disp;
      TGT_ABS:   raw_tgt = disp;
      TGT_LINK:  raw_tgt = link_in;
      TGT_COUNT: raw_tgt = count_in;
      default:   raw_tgt = cur_addr + disp;
    endcase
    raw_seq  = cur_addr + ADDR_W'(4);
    target   = raw_tgt & keep_mask;
    seq_addr = raw_seq & keep_mask;
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       insn_i,
  input  logic              indirect_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ADDR_W-1:0] count_i,
  input  logic [ADDR_W-1:0] link_i,
  input  logic [31:0]       cond_i,
  input  logic              wide_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic [ADDR_W-1:0] count_o,
  output logic [ADDR_W-1:0] link_o
);
  logic [ADDR_W-1:0] cnt_upd;
  logic              go;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] seq_addr;

  logic              taken_d;
  logic [ADDR_W-1:0] next_d;
  logic [ADDR_W-1:0] link_d;
  logic              res_en;

  br_cond_eval #(.ADDR_W(ADDR_W)) u_cond (
    .insn      (insn_i),
    .count_in  (count_i),
    .cond_in   (cond_i),
    .count_out (cnt_upd),
    .go        (go)
  );

  br_target_gen #(.ADDR_W(ADDR_W)) u_tgt (
    .insn     (insn_i),
    .indirect (indirect_i),
    .wide     (wide_i),
    .cur_addr (cur_addr_i),
    .count_in (count_i),
    .link_in  (link_i),
    .target   (target),
    .seq_addr (seq_addr)
  );

  always_comb begin
    res_en  = start_i;
    taken_d = go;
    next_d  = go ? target : seq_addr;
    link_d  = insn_i[0] ? seq_addr : link_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
    end else begin
      done_o <= start_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o     <= 1'b0;
      next_addr_o <= '0;
      count_o     <= '0;
      link_o      <= '0;
    end else if (res_en) begin
      taken_o     <= taken_d;
      next_addr_o <= next_d;
      count_o     <= cnt_upd;
      link_o      <= link_d;
    end
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [31:0]       insn_i,
  input logic [ADDR_W-1:0] cur_addr_i,
  input logic [ADDR_W-1:0] count_i,
  input logic [ADDR_W-1:0] link_i,
  input logic [31:0]       cond_i,
  input logic              wide_i,
  input logic              done_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] next_addr_o,
  input logic [ADDR_W-1:0] count_o,
  input logic [ADDR_W-1:0] link_o
);
  logic [ADDR_W-1:0] seq_full;
  logic              sel_bit;
  assign seq_full = cur_addr_i + ADDR_W'(4);
  assign sel_bit  = cond_i[5'd31 - insn_i[20:16]];

  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && $stable(taken_o) && $stable(next_addr_o)
                  && $stable(count_o) && $stable(link_o)));
  p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !insn_i[23]) |=> count_o == $past(count_i) - ADDR_W'(1));
  p_count_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && insn_i[23]) |=> count_o == $past(count_i));
  p_count_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !insn_i[23] && ((count_i == ADDR_W'(1)) != insn_i[22])) |=> !taken_o);
  p_cond_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !insn_i[25] && (sel_bit != insn_i[24])) |=> !taken_o);
  p_free_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && insn_i[23] && insn_i[25]) |=> taken_o);
  p_seq_nottaken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && wide_i) |=> (taken_o || next_addr_o == $past(seq_full)));
  p_link_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !insn_i[0]) |=> link_o == $past(link_i));
  p_narrow_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !wide_i) |=> next_addr_o[ADDR_W-1:32] == '0);
  p_narrow_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !wide_i && insn_i[0]) |=> link_o[ADDR_W-1:32] == '0);
endmodule

bind branch_resolver branch_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .insn_i      (insn_i),
  .cur_addr_i  (cur_addr_i),
  .count_i     (count_i),
  .link_i      (link_i),
  .cond_i      (cond_i),
  .wide_i      (wide_i),
  .done_o      (done_o),
  .taken_o     (taken_o),
  .next_addr_o (next_addr_o),
  .count_o     (count_o),
  .link_o      (link_o)
);

// File: tb/branch_resolver_test.sv
`timescale 1ns/1ps
module branch_resolver_test;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [31:0]   insn_i;
  logic          indirect_i;
  logic [AW-1:0] cur_addr_i, count_i, link_i;
  logic [31:0]   cond_i;
  logic          wide_i;
  logic          done_o, taken_o;
  logic [AW-1:0] next_addr_o, count_o, link_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic          e_taken;
  logic [AW-1:0] e_next, e_cnt, e_lnk;

  always #10 clk = ~clk;

  branch_resolver #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .indirect_i(indirect_i), .cur_addr_i(cur_addr_i), .count_i(count_i),
    .link_i(link_i), .cond_i(cond_i), .wide_i(wide_i), .done_o(done_o),
    .taken_o(taken_o), .next_addr_o(next_addr_o), .count_o(count_o),
    .link_o(link_o)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected results, worked out from the requirement text
  task automatic model();
    logic [4:0]    opt;
    logic [4:0]    idx;
    logic          cok, rok;
    logic [AW-1:0] dsp, tgt, seq, msk;
    opt = insn_i[25:21];
    idx = insn_i[20:16];
    msk = wide_i ? {AW{1'b1}} : {32'h0, 32'hFFFF_FFFF};
    e_cnt = opt[2] ? count_i : count_i - 64'd1;
    cok = opt[2] ? 1'b1 : ((e_cnt == 64'd0) == opt[1]);
    rok = opt[4] ? 1'b1 : (cond_i[31 - idx] == opt[3]);
    e_taken = cok && rok;
    dsp = {{50{insn_i[15]}}, insn_i[15:2]} * 64'd4;
    if (indirect_i) tgt = insn_i[10] ? count_i : link_i;
    else            tgt = insn_i[1] ? dsp : cur_addr_i + dsp;
    seq = (cur_addr_i + 64'd4) & msk;
    e_next = e_taken ? (tgt & msk) : seq;
    e_lnk = insn_i[0] ? seq : link_i;
  endtask

  task automatic run(input string tag);
    model();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R2 done"}, AW'(done_o), AW'(1));
    chk({tag, " R6 taken"}, AW'(taken_o), AW'(e_taken));
    chk({tag, " R9 next"}, next_addr_o, e_next);
    chk({tag, " R3 count"}, count_o, e_cnt);
    chk({tag, " R10 link"}, link_o, e_lnk);
  endtask

  function automatic logic [31:0] mk(input logic [4:0] opt, input logic [4:0] idx,
                                     input logic [13:0] d, input logic ab, input logic lk);
    return {6'd16, opt, idx, d, ab, lk};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; insn_i = '0; indirect_i = 1'b0;
    cur_addr_i = '0; count_i = '0; link_i = '0; cond_i = '0; wide_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset done", AW'(done_o), '0);
    chk("R1 reset taken", AW'(taken_o), '0);
    chk("R1 reset next", next_addr_o, '0);
    chk("R1 reset count", count_o, '0);
    chk("R1 reset link", link_o, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", AW'(done_o) | next_addr_o | link_o, '0);

    // R4 R5 R6 sweep: every option code, both bit polarities, zero/non-zero count
    cur_addr_i = 64'h0000_1234_5678_0000;
    link_i     = 64'h0000_0000_0000_9000;
    for (int o = 0; o < 32; o++) begin
      for (int b = 0; b < 2; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [4:0] ix;
          ix = 5'((o * 7 + 3) % 32);
          cond_i  = b[0] ? (32'h1 << (31 - ix)) : ~(32'h1 << (31 - ix));
          count_i = c[0] ? 64'd1 : 64'd2;
          insn_i  = mk(5'(o), ix, 14'h0010, 1'b0, 1'b0);
          run("R4/R5 sweep");
        end
      end
    end

    // R7 negative relative displacement, always-taken option
    count_i = 64'd7;
    insn_i = mk(5'b10100, 5'd0, 14'h3FFF, 1'b0, 1'b0);
    run("R7 neg rel");
    // R7 absolute positive and negative
    insn_i = mk(5'b10100, 5'd0, 14'h1000, 1'b1, 1'b0);
    run("R7 abs pos");
    insn_i = mk(5'b10100, 5'd0, 14'h2000, 1'b1, 1'b0);
    run("R7 abs neg");
    // R11 same absolute negative in 32-bit mode
    wide_i = 1'b0;
    run("R11 abs neg narrow");
    wide_i = 1'b1;

    // R8 indirect via count with decrement: target uses old count
    indirect_i = 1'b1;
    count_i = 64'h0000_0000_0000_0100;
    link_i  = 64'h0000_0000_0000_5550;
    insn_i = mk(5'b10000, 5'd0, 14'h0100, 1'b0, 1'b0);
    run("R8 via count");
    // R8 R10 indirect via link with link write
    insn_i = mk(5'b10100, 5'd0, 14'h0000, 1'b0, 1'b1);
    run("R8 via link");
    indirect_i = 1'b0;

    // R10 not taken still writes link
    cond_i = 32'h0;
    insn_i = mk(5'b01100, 5'd2, 14'h0020, 1'b0, 1'b1);
    run("R10 nottaken link");

    // R3 zero count wraps to all ones, non-zero test taken
    count_i = 64'd0;
    insn_i = mk(5'b10000, 5'd0, 14'h0008, 1'b0, 1'b0);
    run("R3 wrap");

    // R11 32-bit mode with carry out of bit 31
    wide_i = 1'b0;
    cur_addr_i = 64'h0000_0003_FFFF_FFFC;
    insn_i = mk(5'b10100, 5'd0, 14'h0004, 1'b0, 1'b1);
    run("R11 narrow carry");
    insn_i = mk(5'b00100, 5'd0, 14'h0004, 1'b0, 1'b1);
    cond_i = 32'hFFFF_FFFF;
    run("R11 narrow nottaken");
    wide_i = 1'b1;

    // R2 hold: change inputs without a strobe
    begin
      logic [AW-1:0] hn, hc, hl;
      logic ht;
      hn = next_addr_o; hc = count_o; hl = link_o; ht = taken_o;
      cur_addr_i = 64'hDEAD_0000_0000_0000; count_i = 64'd99; link_i = 64'd77;
      insn_i = mk(5'b10100, 5'd0, 14'h0abc, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      chk("R2 hold done", AW'(done_o), '0);
      chk("R2 hold taken", AW'(taken_o), AW'(ht));
      chk("R2 hold next", next_addr_o, hn);
      chk("R2 hold count", count_o, hc);
      chk("R2 hold link", link_o, hl);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule